// File: doc/BRIEF.md
# Serial Port Word Buffer with Shared Error Status

This block holds the data words of one synchronous serial port channel and keeps its error status. A direction input selects receive or transmit. In receive, serial bits are shifted in most significant bit first. Each completed word moves into a two-entry holding buffer that the host drains with a read strobe. A receive interrupt stays high while that buffer holds data.

In transmit, the host writes words into the same holding buffer. Each frame sync loads the oldest held word into the shift register, which drives it out one bit per serial slot.

One sticky error flag covers both directions. In receive it means overflow: a third word completed while two words were still held, so the third word overwrote the newer held word. In transmit it means underflow: a frame sync arrived with nothing written, and the previous word was sent again. The flag clears only when the port is disabled. The flag appears at bit 29 of a status word, and the fill level appears at its low bits.

Top module: `sport_buf`

## Requirements
- R1: In receive, a frame starts on a cycle with `fs` and `bit_en` both high and the port idle, and that cycle samples the MSB. The next W-1 cycles with `bit_en` high each sample one more bit, and cycles without `bit_en` are skipped. On the edge that samples the final bit, the word enters the holding buffer, so `fill` rises in the following cycle.
- R2: The holding buffer keeps at most two words. `rd_data` shows the oldest held word. In receive, `rd_stb` removes the oldest word and moves the newer one forward. A read while the buffer is empty changes nothing.
- R3: In receive with two words held, a completed word replaces the newer held word and sets `err`. `err` is still low in the cycle that presents the final bit, and it is high in the cycle after it.
- R4: In receive with two words held, if `rd_stb` and the final bit of a word arrive in the same cycle, `err` stays low and `fill` stays at 2. The held words become the former newer word followed by the new word.
- R5: `irq_rx` is high exactly when the port is enabled, set to receive, and `fill` is nonzero. It is never high in transmit.
- R6: In transmit, `wr_stb` stores `wr_data` as the newest word, unless two words are already held, in which case the write is dropped. `wr_stb` has no effect in receive, and `rd_stb` has no effect in transmit.
- R7: In transmit, a frame sync while idle with at least one word held removes the oldest word. Its MSB appears on `tx_bit` in the cycle after the frame sync, and each later `bit_en` cycle advances `tx_bit` by one bit.
- R8: In transmit, a frame sync while idle with no word held sets `err` and sends again the last word sent. If no word has been sent since the port was enabled, it sends all zeros.
- R9: Once set, `err` stays high for as long as `en` stays high. A cycle with `en` low clears `err`, `fill`, `irq_rx`, the shift register and the last-sent word.
- R10: `status` carries `err` at bit 29 and `fill` at bits 1:0. All other bits of `status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Port enable; low clears state |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| bit_en | input | 1 | Serial bit slot strobe |
| fs | input | 1 | Frame sync |
| rx_bit | input | 1 | Serial receive data |
| tx_bit | output | 1 | Serial transmit data |
| rd_stb | input | 1 | Host read strobe (receive) |
| rd_data | output | W | Oldest held word |
| wr_stb | input | 1 | Host write strobe (transmit) |
| wr_data | input | W | Word to transmit |
| irq_rx | output | 1 | Receive data ready |
| fill | output | 2 | Number of held words |
| status | output | 32 | Status word: error at bit 29, fill at bits 1:0 |

## Verification
The results become visible at different times. `fill`, `err` and `irq_rx` follow the edge that samples a word's final bit, so they are valid in the next cycle. `rd_data` is valid in the same cycle as the read strobe. `tx_bit` gives the MSB in the cycle after the frame-sync edge and one new bit after each later slot. The bench drives inputs and samples outputs on falling edges. Each value is read at the first falling edge after the rising edge that produces it, and for R3 the error flag is also read just before the final bit takes effect. The sweeps cover every count of received and written words up to one past the overflow point and up to three frames, with and without idle gaps between slots, and compute each expected word arithmetically.

// File: rtl/sport_buf.sv
module sport_buf #(
  parameter int W       = 32,
  parameter int ERR_POS = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dir_tx,
  input  logic         bit_en,
  input  logic         fs,
  input  logic         rx_bit,
  output logic         tx_bit,
  input  logic         rd_stb,
  output logic [W-1:0] rd_data,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  output logic         irq_rx,
  output logic [1:0]   fill,
  output logic [31:0]  status
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  h0, h1, sh, last_w;
  logic [1:0]    fill_q;
  logic          busy, err;
  logic [CW-1:0] bitcnt;

  wire slot  = en & bit_en;
  wire start = slot & fs & ~busy;
  wire step  = slot & busy;
  wire done  = step & (bitcnt == LAST);
  wire empty = (fill_q == 2'd0);
  wire full  = (fill_q == 2'd2);

  wire [W-1:0] sh_in = {sh[W-2:0], rx_bit};
  wire [W-1:0] new_w = dir_tx ? wr_data : sh_in;
  wire [W-1:0] tx_ld = empty ? last_w : h0;

  wire push = dir_tx ? (en & wr_stb & ~full) : done;
  wire pop  = dir_tx ? (start & ~empty) : (en & rd_stb & ~empty);
  wire ovf  = ~dir_tx & push & ~pop & full;
  wire unf  = dir_tx & start & empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 <= '0; h1 <= '0; fill_q <= 2'd0;
    end else if (!en) begin
      h0 <= '0; h1 <= '0; fill_q <= 2'd0;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (empty) h0 <= new_w;
          else       h1 <= new_w;
          if (!full) fill_q <= fill_q + 2'd1;
        end
        2'b01: begin
          h0 <= h1;
          fill_q <= fill_q - 2'd1;
        end
        2'b11: begin
          if (full) begin
            h0 <= h1;
            h1 <= new_w;
          end else begin
            h0 <= new_w;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; last_w <= '0; busy <= 1'b0; bitcnt <= '0;
    end else if (!en) begin
      sh <= '0; last_w <= '0; busy <= 1'b0; bitcnt <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      bitcnt <= CW'(1);
      if (dir_tx) begin
        sh     <= tx_ld;
        last_w <= tx_ld;
      end else begin
        sh <= sh_in;
      end
    end else if (step) begin
      sh <= dir_tx ? {sh[W-2:0], 1'b0} : sh_in;
      if (done) busy <= 1'b0;
      else      bitcnt <= bitcnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err <= 1'b0;
    else if (!en) err <= 1'b0;
    else          err <= err | ovf | unf;
  end

  assign rd_data = h0;
  assign fill    = fill_q;
  assign tx_bit  = en & dir_tx & sh[W-1];
  assign irq_rx  = en & ~dir_tx & ~empty;

  always_comb begin
    status          = '0;
    status[1:0]     = fill_q;
    status[ERR_POS] = err;
  end
endmodule

// File: rtl/sport_buf_chk.sv
module sport_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       dir_tx,
  input logic       bit_en,
  input logic       fs,
  input logic       rd_stb,
  input logic       busy,
  input logic       err,
  input logic       irq_rx,
  input logic [1:0] fill
);
  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill != 2'd3); // R2
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fill == 2'd0) |=> fill != 2'd2); // R1
  AST_NO_OVF_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dir_tx && rd_stb && fill == 2'd2) |=> !$rose(err)); // R4
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_tx && fs && bit_en && !busy && fill == 2'd0) |=> err); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && err) |=> err); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fill == 2'd0 && !err && !irq_rx)); // R9
  AST_IRQ_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dir_tx |-> !irq_rx); // R5
endmodule

bind sport_buf sport_buf_chk u_chk (.*);

// File: tb/tb_sport_buf.sv
module tb_sport_buf;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, en = 0, dir_tx = 0, bit_en = 0, fs = 0, rx_bit = 0;
  logic rd_stb = 0, wr_stb = 0;
  logic [W-1:0] wr_data = '0;
  logic tx_bit, irq_rx;
  logic [W-1:0] rd_data;
  logic [1:0] fill;
  logic [31:0] status;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sport_buf dut (.clk, .rst_n, .en, .dir_tx, .bit_en, .fs, .rx_bit, .tx_bit,
                 .rd_stb, .rd_data, .wr_stb, .wr_data, .irq_rx, .fill, .status);

  function automatic int mn(int a, int b); return a < b ? a : b; endfunction
  function automatic logic [31:0] pat(int k);
    return 32'h8C3A_51E7 ^ (32'h1234_5679 * (k + 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic reset_port(input logic d);
    @(negedge clk); en = 0; dir_tx = d;
    @(negedge clk);
    chk("R9 clear fill", {30'b0, fill}, 0);
    chk("R9 clear irq", {31'b0, irq_rx}, 0);
    chk("R10 clear status", status, 0);
    en = 1;
  endtask

  task automatic rx_word(input logic [31:0] w, input bit gap, input bit rd_last,
                         output logic err_before);
    err_before = 0;
    for (int i = 0; i < W; i++) begin
      if (gap) begin @(negedge clk); bit_en = 0; fs = 0; rd_stb = 0; end
      @(negedge clk);
      if (i == W-1) err_before = status[29];
      bit_en = 1; fs = (i == 0); rx_bit = w[W-1-i]; rd_stb = rd_last && (i == W-1);
    end
    @(negedge clk); bit_en = 0; fs = 0; rd_stb = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); rd_stb = 1; d = rd_data;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_stb = 1; wr_data = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic tx_frame(output logic [31:0] got);
    @(negedge clk); fs = 1; bit_en = 1;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      got[W-1-i] = tx_bit;
      fs = 0; bit_en = (i < W-1);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic eb;
    logic [31:0] d, last;
    repeat (3) @(negedge clk);
    chk("R9 reset fill", {30'b0, fill}, 0);
    chk("R10 reset status", status, 0);
    rst_n = 1;

    for (int g = 0; g < 2; g++)
      for (int n = 0; n <= 4; n++) begin
        reset_port(0);
        for (int k = 0; k < n; k++) begin
          rx_word(pat(k), g[0], 0, eb);
          if (k == 2) chk("R3 err low before final bit", {31'b0, eb}, 0);
        end
        chk("R1 fill after words", {30'b0, fill}, mn(n, 2));
        chk("R3 overflow flag", {31'b0, status[29]}, (n >= 3) ? 1 : 0);
        chk("R5 irq with data", {31'b0, irq_rx}, (n > 0) ? 1 : 0);
        chk("R10 status word", status, ((n >= 3) ? 32'h2000_0000 : 0) | mn(n, 2));
        for (int r = 0; r < mn(n, 2); r++) begin
          rd(d);
          chk("R2 read order", d, (r == 0) ? pat(0) : ((n >= 3) ? pat(n-1) : pat(1)));
        end
        rd(d);
        chk("R2 empty read", {30'b0, fill}, 0);
        chk("R5 irq drained", {31'b0, irq_rx}, 0);
        chk("R9 err sticky after reads", {31'b0, status[29]}, (n >= 3) ? 1 : 0);
      end

    reset_port(0);
    rx_word(pat(20), 0, 0, eb);
    rx_word(pat(21), 0, 0, eb);
    rx_word(pat(22), 1, 1, eb);
    chk("R4 no overflow", {31'b0, status[29]}, 0);
    chk("R4 fill stays", {30'b0, fill}, 2);
    rd(d); chk("R4 first word", d, pat(21));
    rd(d); chk("R4 second word", d, pat(22));

    reset_port(0);
    wr(32'hDEAD_BEEF);
    chk("R6 write ignored in rx", {30'b0, fill}, 0);

    for (int nw = 0; nw <= 3; nw++)
      for (int nf = 1; nf <= 3; nf++) begin
        reset_port(1);
        for (int k = 0; k < nw; k++) wr(pat(10 + k));
        chk("R6 tx fill", {30'b0, fill}, mn(nw, 2));
        chk("R5 no irq in tx", {31'b0, irq_rx}, 0);
        if (nw == 2) begin
          rd(d);
          chk("R6 read ignored in tx", {30'b0, fill}, 2);
        end
        last = 0;
        for (int f = 0; f < nf; f++) begin
          tx_frame(d);
          if (f < mn(nw, 2)) begin
            chk("R7 tx word", d, pat(10 + f));
            last = pat(10 + f);
          end else chk("R8 underflow resend", d, last);
        end
        chk("R8 underflow flag", {31'b0, status[29]}, (nf > mn(nw, 2)) ? 1 : 0);
        chk("R7 fill after frames", {30'b0, fill}, mn(nw, 2) - mn(nf, mn(nw, 2)));
      end

    report();
  end
endmodule